// File: doc/BRIEF.md
# Two-Stage Master Clock Output Generator

This block produces the master clock that drives an audio codec. Five clock sources reach it, each modelled as a one-cycle edge strobe in a single fast system clock. Four of them feed a first stage: a 2-bit field picks one strobe, an enable bit gates it, and an 8-bit programmable divider counts the gated strobes. A second stage picks either the divided result or the fifth source, a recovered receive clock. That source passes neither the gate nor the divider. The output is a registered square wave.

Changing either select field triggers a short quiet period. The output is forced low and the divider is cleared for at least one full system cycle. Only then does the new source start to drive the output, so a reconfiguration never produces a runt pulse.

The controller is a four-state machine. `ST_QUIET` is entered on reset and on any select change. It leaves to `ST_RUN_BYP` when the latched output select is 1. Otherwise it leaves to `ST_RUN_DIV` when the enable is set, or to `ST_GATED` when it is clear. Any select change in any state leads back to `ST_QUIET`. A change seen in `ST_QUIET` keeps it there. `ST_RUN_DIV` goes to `ST_GATED` when the enable clears. `ST_GATED` goes to `ST_RUN_DIV` when the enable sets.

Top module: `mclk_gen`

## Requirements
- R1: During reset and in the first two cycles after it, `mclk_out` is 0.
- R2: In the divided path, `src_sel` values 0, 1, 2 and 3 pick `src_strobe[0]` (oscillator), `src_strobe[1]` (system reference), `src_strobe[2]` (external master input) and `src_strobe[3]` (external audio transmit) respectively. Strobes on unselected sources do not change the output.
- R3: With `out_sel`=0 and `enable`=1, `mclk_out` inverts on every (`div_n`+1)-th strobe of the selected source. The output period is 2·(`div_n`+1) strobes at 50 percent duty. The register updates on the clock edge that samples the strobe.
- R4: With `out_sel`=0 and `enable`=0, `mclk_out` is 0 from the next edge on, and selected-source strobes are ignored. The divider count is cleared, so after re-enabling it takes a full `div_n`+1 strobes to reach the next inversion.
- R5: With `out_sel`=1, `mclk_out` inverts on every `rx_strobe`. `enable`, `div_n` and all `src_strobe` inputs have no effect.
- R6: A change of `src_sel` or `out_sel` forces `mclk_out` to 0 at the next edge and keeps it 0 at the edge after that. Strobes sampled at those two edges are ignored. The divider restarts from zero.
- R7: With `out_sel`=0, `rx_strobe` has no effect on `mclk_out`.
- R8: With `div_n`=0 in the divided path, `mclk_out` inverts on every selected strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_strobe | input | 4 | Edge strobes of the four first-stage sources |
| rx_strobe | input | 1 | Edge strobe of the recovered receive clock (bypass source) |
| src_sel | input | 2 | First-stage source select |
| out_sel | input | 1 | Second-stage select: 0 divided path, 1 bypass |
| enable | input | 1 | Gate for the first-stage source |
| div_n | input | 8 | Divider setting; inversion every `div_n`+1 strobes |
| mclk_out | output | 1 | Registered master clock output |

## Verification
The assertions assume the strobes are plain synchronous pulses. They also assume the select fields, enable and divider value change only between clock edges, so every change is seen as a clean one-edge difference against the latched configuration. The bench drives all inputs on the falling edge and makes each strobe exactly one cycle wide. It changes `div_n` only when the divider is idle or cleared, so the divider count never starts above a newly lowered limit. Select changes are applied one at a time, with idle cycles after each, so each quiet period runs to completion before the next strobe.

// File: rtl/mclk_pkg.sv
package mclk_pkg;

    localparam int MCLK_NUM_SRC = 4;

    typedef enum logic [1:0] {
        ST_QUIET   = 2'd0,
        ST_GATED   = 2'd1,
        ST_RUN_DIV = 2'd2,
        ST_RUN_BYP = 2'd3
    } mclk_state_e;

endpackage

// File: rtl/mclk_src_sel.sv
module mclk_src_sel #(
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_SRC-1:0] src_strobe,
    input  logic [SEL_W-1:0]   sel,
    input  logic               enable,
    output logic               gated_strobe
);

    logic [NUM_SRC-1:0] hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = src_strobe[g] && (sel == SEL_W'(g));
    end

    // The gate sits ahead of the divider: a disabled source never reaches it.
    assign gated_strobe = enable && (|hit);

endmodule

// File: rtl/mclk_divider.sv
module mclk_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             strobe,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic             at_limit;

    assign at_limit = (cnt_q >= div_n);
    assign tick     = strobe && at_limit && !clr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (strobe) begin
            cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
        end
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/mclk_gen.sv
module mclk_gen
    import mclk_pkg::*;
#(
    parameter  int NUM_SRC = MCLK_NUM_SRC,
    parameter  int DIV_W   = 8,
    localparam int SEL_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_strobe,
    input  logic               rx_strobe,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic               out_sel,
    input  logic               enable,
    input  logic [DIV_W-1:0]   div_n,
    output logic               mclk_out
);

    mclk_state_e      state_q, state_d;
    logic [SEL_W-1:0] src_sel_q;
    logic             out_sel_q;
    logic             cfg_change;
    logic             gated_strobe;
    logic             div_clr;
    logic             div_tick;
    logic             out_q;

    assign cfg_change = (src_sel != src_sel_q) || (out_sel != out_sel_q);

    mclk_src_sel #(
        .NUM_SRC (NUM_SRC),
        .SEL_W   (SEL_W)
    ) u_src_sel (
        .src_strobe   (src_strobe),
        .sel          (src_sel_q),
        .enable       (enable),
        .gated_strobe (gated_strobe)
    );

    assign div_clr = (state_q != ST_RUN_DIV) || (state_d != ST_RUN_DIV);

    mclk_divider #(
        .DIV_W (DIV_W)
    ) u_divider (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (div_clr),
        .strobe (gated_strobe),
        .div_n  (div_n),
        .tick   (div_tick)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (cfg_change)     state_d = ST_QUIET;
                else if (out_sel_q) state_d = ST_RUN_BYP;
                else if (enable)    state_d = ST_RUN_DIV;
                else                state_d = ST_GATED;
            end
            ST_GATED: begin
                if (cfg_change)  state_d = ST_QUIET;
                else if (enable) state_d = ST_RUN_DIV;
            end
            ST_RUN_DIV: begin
                if (cfg_change)   state_d = ST_QUIET;
                else if (!enable) state_d = ST_GATED;
            end
            ST_RUN_BYP: begin
                if (cfg_change) state_d = ST_QUIET;
            end
        endcase
    end

    // State and configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_QUIET;
            src_sel_q <= '0;
            out_sel_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cfg_change) begin
                src_sel_q <= src_sel;
                out_sel_q <= out_sel;
            end
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (state_d == ST_QUIET || state_d == ST_GATED) begin
            out_q <= 1'b0;
        end else if (state_q == ST_RUN_DIV && div_tick) begin
            out_q <= ~out_q;
        end else if (state_q == ST_RUN_BYP && rx_strobe) begin
            out_q <= ~out_q;
        end
    end

    assign mclk_out = out_q;

    AST_CHANGE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_change |=> (state_q == ST_QUIET && !mclk_out)); // R6

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_QUIET) |=> !mclk_out); // R6

    AST_GATED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GATED) |-> !mclk_out); // R4

    AST_BYP_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN_BYP && !cfg_change && rx_strobe)
        |=> (mclk_out != $past(mclk_out))); // R5

    AST_DIV_RX_IGN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN_DIV && !cfg_change && enable && !div_tick)
        |=> $stable(mclk_out)); // R7

endmodule

// File: tb/tb_mclk_gen.sv
module tb_mclk_gen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] src_strobe;
    logic       rx_strobe;
    logic [1:0] src_sel;
    logic       out_sel;
    logic       enable;
    logic [7:0] div_n;
    logic       mclk_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mclk_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_strobe (src_strobe),
        .rx_strobe  (rx_strobe),
        .src_sel    (src_sel),
        .out_sel    (out_sel),
        .enable     (enable),
        .div_n      (div_n),
        .mclk_out   (mclk_out)
    );

    task automatic chk(input logic exp, input string req, input string what);
        checks++;
        if (mclk_out !== exp) begin
            errors++;
            $display("FAIL %s %s: got %b expected %b", req, what, mclk_out, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_src(input int i);
        src_strobe[i] = 1'b1;
        @(negedge clk);
        src_strobe = '0;
    endtask

    task automatic pulse_rx();
        rx_strobe = 1'b1;
        @(negedge clk);
        rx_strobe = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        chk(1'b0, "R1", "in reset");
        rst_n = 1'b1;
        idle(2);
        chk(1'b0, "R1", "after reset");
    endtask

    task automatic t_divide();
        for (int k = 0; k < 4; k++) begin
            src_sel = 2'(k);
            enable  = 1'b1;
            div_n   = 8'd2;
            idle(2);
            chk(1'b0, "R2", "after select");
            repeat (2) pulse_src((k + 1) % 4);
            chk(1'b0, "R2", "unselected source ignored");
            repeat (2) pulse_src(k);
            chk(1'b0, "R3", "before N+1 strobes");
            pulse_src(k);
            chk(1'b1, "R3", "at N+1 strobes");
            repeat (2) pulse_src(k);
            chk(1'b1, "R3", "high half");
            pulse_src(k);
            chk(1'b0, "R3", "full period");
        end
    endtask

    task automatic t_gate();
        div_n = 8'd3;
        repeat (2) pulse_src(3);
        enable = 1'b0;
        idle(1);
        chk(1'b0, "R4", "gated low");
        repeat (5) pulse_src(3);
        chk(1'b0, "R4", "strobes ignored while gated");
        enable = 1'b1;
        idle(1);
        repeat (3) pulse_src(3);
        chk(1'b0, "R4", "count restarted");
        pulse_src(3);
        chk(1'b1, "R4", "inversion after full count");
        enable = 1'b0;
        idle(1);
        chk(1'b0, "R4", "high output forced low");
    endtask

    task automatic t_div0();
        enable = 1'b1;
        div_n  = 8'd0;
        idle(1);
        pulse_src(3);
        chk(1'b1, "R8", "first strobe");
        pulse_src(3);
        chk(1'b0, "R8", "second strobe");
        pulse_src(3);
        chk(1'b1, "R8", "third strobe");
    endtask

    task automatic t_switch();
        src_sel       = 2'd1;
        src_strobe[1] = 1'b1;
        @(negedge clk);
        src_strobe = '0;
        chk(1'b0, "R6", "forced low on change");
        pulse_src(1);
        chk(1'b0, "R6", "quiet cycle ignores strobe");
        pulse_src(1);
        chk(1'b1, "R6", "new source active");
    endtask

    task automatic t_bypass();
        out_sel = 1'b1;
        idle(1);
        chk(1'b0, "R6", "second-stage change forces low");
        idle(1);
        pulse_rx();
        chk(1'b1, "R5", "rx strobe 1");
        pulse_rx();
        chk(1'b0, "R5", "rx strobe 2");
        pulse_src(1);
        chk(1'b0, "R5", "first-stage strobe ignored");
        enable = 1'b0;
        div_n  = 8'd7;
        pulse_rx();
        chk(1'b1, "R5", "enable and divider ignored");
        pulse_rx();
        chk(1'b0, "R5", "rx strobe 4");
    endtask

    task automatic t_rx_ignored();
        out_sel = 1'b0;
        enable  = 1'b1;
        div_n   = 8'd1;
        idle(2);
        repeat (3) pulse_rx();
        chk(1'b0, "R7", "rx ignored in divided path");
        repeat (2) pulse_src(1);
        chk(1'b1, "R7", "divided path still counts");
    endtask

    initial begin
        rst_n      = 1'b0;
        src_strobe = '0;
        rx_strobe  = 1'b0;
        src_sel    = 2'd0;
        out_sel    = 1'b0;
        enable     = 1'b0;
        div_n      = 8'd0;
        @(negedge clk);
        t_reset();
        t_divide();
        t_gate();
        t_div0();
        t_switch();
        t_bypass();
        t_rx_ignored();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule